// File: doc/BRIEF.md
# Video Controller Host Port Decoder

This block sits between a CPU bus and a tile-based video controller. The CPU sees two 16-bit ports selected by a small byte offset: a data port and a control port. A control-port write is one of two things. It can set one of the controller's internal 8-bit registers. It can also be one half of a two-word access command, which selects a target memory, a transfer direction and a 16-bit start address. The target memory is graphics RAM, the color table or the vertical scroll RAM.

After a command, every data-port access moves one word to or from the selected target through a request, address and data interface, and the address advances by one word. Reading the control port returns a status word built from the controller's DMA, horizontal-blank and vertical-blank indications. If the second command word carries the block-transfer flag, the block hands the command to a DMA engine outside it and does not run a CPU transfer.

Top module: `hpd_top`

## Requirements
- R1: The port is selected by `bus_addr[2]` alone: offsets 0 and 2 both act as the data port, and offsets 4 and 6 both act as the control port.
- R2: A first command word with bits [15:14] = 01, followed by a second word with bits [5:4] = 00, selects graphics RAM (target code 0) for writes. The start address is `{second[1:0], first[13:0]}`. Each later data-port write then raises `mem_req` with `mem_we`=1 for one cycle, in the cycle after the bus access.
- R3: The color table (target code 1) is selected either by first-word bits [15:14] = 11, which gives a write, or by second-word bit 5 = 1 with first-word bits [15:14] = 00, which gives a read.
- R4: Second-word bit 4 = 1 (with bit 5 = 0) selects the vertical scroll RAM (target code 2). First-word bit 14 = 1 gives a write and bit 14 = 0 gives a read.
- R5: Address bit 0 is dropped: `mem_addr[0]` is 0 on every request, even when the command address is odd.
- R6: Every data-port access advances the command address by 2, wrapping modulo 2^16.
- R7: A data-port read whose direction matches the command issues `mem_req` with `mem_we`=0. The word on `mem_rdata` in that request cycle appears on `bus_rdata` after the next clock edge. An access whose direction does not match the command issues no request but still advances the address.
- R8: A second command word with bit 7 = 1 pulses `dma_start` for one cycle, in the cycle after that word. During the pulse, `mem_addr` and `mem_target` carry the new command, and no `mem_req` is issued.
- R9: A control-port read loads `bus_rdata` in the next cycle with the status word: bit 1 = DMA busy, bit 2 = horizontal blank, bit 3 = vertical blank, and all other bits 0.
- R10: When no command is pending, a control write 0b10_iiiiii_vvvvvvvv with index iiiiii ≤ 23 pulses `reg_we` in the next cycle with `reg_idx`=iiiiii and `reg_val`=vvvvvvvv. An index above 23 has no effect.
- R11: A first command word sets a pending flag. The next control write completes the command. A data-port access or a status read clears the flag, so the following control write is decoded as a fresh first word or register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | CPU access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Byte offset bits [2:1] |
| bus_wdata | input | 16 | CPU write word |
| bus_rdata | output | 16 | CPU read word (status or memory data) |
| dma_busy | input | 1 | DMA engine busy |
| hblank | input | 1 | Horizontal blank |
| vblank | input | 1 | Vertical blank |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Request is a write |
| mem_target | output | 2 | 0 graphics RAM, 1 color table, 2 vertical scroll RAM |
| mem_addr | output | 16 | Word-aligned byte address |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word, valid in the request cycle |
| dma_start | output | 1 | One-cycle block-transfer start |
| reg_we | output | 1 | Internal register write strobe |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register value |

## Verification
The CPU access cycle is the reference point. One clock after it, `mem_req`, `reg_we` and `dma_start`, together with their address, target and data, are due, and so is a status word on `bus_rdata`. Read data from memory reaches `bus_rdata` one clock later than that. The bench's reference model applies the same offsets: its pulse expectations follow the access edge, and its expected read data follows the request edge. All outputs are compared at the falling edge of every cycle, half a period after the edge that updated them.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  typedef enum logic [1:0] {
    TGT_GFX     = 2'd0,
    TGT_COLOR   = 2'd1,
    TGT_VSCROLL = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e        tgt;
    logic        wr;
    logic [15:0] addr;
  } cmd_t;
endpackage

// File: rtl/hpd_cmd_decode.sv
module hpd_cmd_decode
  import hpd_pkg::*;
#(
  parameter int DW       = 16,
  parameter int IDXW     = 5,
  parameter int REG_LAST = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic            ctl_rd,
  input  logic            data_acc,
  input  logic [DW-1:0]   wdata,
  output logic            cmd_load,
  output logic            dma_go,
  output cmd_t            cmd_new,
  output logic            reg_we,
  output logic [IDXW-1:0] reg_idx,
  output logic [7:0]      reg_val
);
  localparam int FW = 6;

  logic          pend_q, pend_d;
  logic [DW-1:0] first_q, first_d;
  logic          rwe_q, rwe_d;
  logic [IDXW-1:0] ridx_q, ridx_d;
  logic [7:0]    rval_q, rval_d;
  logic          is_reg, in_range, start;
  logic [FW-1:0] idx_field;

  always_comb begin
    is_reg    = (wdata[15:14] == 2'b10);
    idx_field = wdata[13:8];
    in_range  = (int'(idx_field) <= REG_LAST);
    cmd_load  = ctl_wr & pend_q;
    start     = ctl_wr & ~pend_q & ~is_reg;
    dma_go    = cmd_load & wdata[7];

    cmd_new.addr = {wdata[1:0], first_q[13:0]};
    cmd_new.wr   = first_q[14];
    if ((first_q[15] & first_q[14]) | wdata[5]) cmd_new.tgt = TGT_COLOR;
    else if (wdata[4])                          cmd_new.tgt = TGT_VSCROLL;
    else                                        cmd_new.tgt = TGT_GFX;

    pend_d = pend_q;
    if (cmd_load | data_acc | ctl_rd) pend_d = 1'b0;
    else if (start)                   pend_d = 1'b1;

    first_d = first_q;
    if (start) first_d = wdata;

    rwe_d  = ctl_wr & ~pend_q & is_reg & in_range;
    ridx_d = ridx_q;
    rval_d = rval_q;
    if (rwe_d) begin
      ridx_d = idx_field[IDXW-1:0];
      rval_d = wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      first_q <= '0;
      rwe_q   <= 1'b0;
      ridx_q  <= '0;
      rval_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      first_q <= first_d;
      rwe_q   <= rwe_d;
      ridx_q  <= ridx_d;
      rval_q  <= rval_d;
    end
  end

  assign reg_we  = rwe_q;
  assign reg_idx = ridx_q;
  assign reg_val = rval_q;

  p_pend_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc | ctl_rd) |=> !pend_q);
  p_pend_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !pend_q && wdata[15:14] != 2'b10) |=> pend_q);
  p_reg_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (int'(reg_idx) <= REG_LAST));
endmodule

// File: rtl/hpd_xfer.sv
module hpd_xfer
  import hpd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dma_go,
  input  cmd_t          cmd_in,
  input  logic          acc,
  input  logic          acc_wr,
  input  logic [DW-1:0] wdata,
  input  logic          status_rd,
  input  logic [DW-1:0] status_word,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_target,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          dma_start,
  output logic [DW-1:0] rdata
);
  cmd_t          cur_q, cur_d;
  logic          req_q, req_d, we_q, we_d, dma_q, dma_d, rdp_q, rdp_d;
  logic [1:0]    tgt_q, tgt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d, rd_q, rd_d;
  logic          issue, out_en;

  always_comb begin
    issue  = acc & (acc_wr == cur_q.wr);
    out_en = issue | dma_go;

    cur_d = cur_q;
    if (load)     cur_d = cmd_in;
    else if (acc) cur_d.addr = cur_q.addr + AW'(STEP);

    req_d = issue;
    we_d  = issue & acc_wr;
    dma_d = dma_go;
    rdp_d = issue & ~acc_wr;

    tgt_d  = tgt_q;
    addr_d = addr_q;
    if (out_en) begin
      tgt_d  = issue ? cur_q.tgt : cmd_in.tgt;
      addr_d = issue ? {cur_q.addr[AW-1:1], 1'b0} : {cmd_in.addr[AW-1:1], 1'b0};
    end
    wd_d = wd_q;
    if (issue & acc_wr) wd_d = wdata;

    rd_d = rd_q;
    if (status_rd)  rd_d = status_word;
    else if (rdp_q) rd_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      dma_q  <= 1'b0;
      rdp_q  <= 1'b0;
      tgt_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      cur_q  <= cur_d;
      req_q  <= req_d;
      we_q   <= we_d;
      dma_q  <= dma_d;
      rdp_q  <= rdp_d;
      tgt_q  <= tgt_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
    end
  end

  assign mem_req    = req_q;
  assign mem_we     = we_q;
  assign mem_target = tgt_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wd_q;
  assign dma_start  = dma_q;
  assign rdata      = rd_q;

  p_dma_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> !mem_req);
  p_we_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_we == $past(acc_wr)));
  p_even_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(load, 2)) |-> (mem_addr == $past({cmd_in.addr[AW-1:1], 1'b0}, 2)));
endmodule

// File: rtl/hpd_top.sv
module hpd_top
  import hpd_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter int STEP     = 2,
  parameter int IDXW     = 5,
  parameter int REG_LAST = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [2:1]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            dma_busy,
  input  logic            hblank,
  input  logic            vblank,
  output logic            mem_req,
  output logic            mem_we,
  output logic [1:0]      mem_target,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            dma_start,
  output logic            reg_we,
  output logic [IDXW-1:0] reg_idx,
  output logic [7:0]      reg_val
);
  logic          ctl_sel, data_sel, ctl_wr, ctl_rd, cmd_load, dma_go;
  logic [DW-1:0] status_word;
  cmd_t          cmd_new;

  always_comb begin
    ctl_sel     = bus_sel & bus_addr[2];
    data_sel    = bus_sel & ~bus_addr[2];
    ctl_wr      = ctl_sel & bus_wr;
    ctl_rd      = ctl_sel & ~bus_wr;
    status_word = '0;
    status_word[1] = dma_busy;
    status_word[2] = hblank;
    status_word[3] = vblank;
  end

  hpd_cmd_decode #(.DW(DW), .IDXW(IDXW), .REG_LAST(REG_LAST)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .data_acc(data_sel), .wdata(bus_wdata), .cmd_load(cmd_load),
    .dma_go(dma_go), .cmd_new(cmd_new), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_val(reg_val)
  );

  hpd_xfer #(.DW(DW), .AW(AW), .STEP(STEP)) u_xfer (
    .clk(clk), .rst_n(rst_n), .load(cmd_load), .dma_go(dma_go),
    .cmd_in(cmd_new), .acc(data_sel), .acc_wr(bus_wr), .wdata(bus_wdata),
    .status_rd(ctl_rd), .status_word(status_word), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_target(mem_target),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dma_start(dma_start),
    .rdata(bus_rdata)
  );

  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, reg_we, dma_start}));
  p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[2]) |=>
      (bus_rdata[3:1] == $past({vblank, hblank, dma_busy})) && (bus_rdata[0] == 1'b0));
endmodule

// File: tb/hpd_top_test.sv
module hpd_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:1]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dma_busy = 1'b0, hblank = 1'b0, vblank = 1'b0;
  logic        mem_req, mem_we, dma_start, reg_we;
  logic [1:0]  mem_target;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_val;

  int total = 0;
  int bad = 0;
  string cur_req = "R0";

  always #2 clk = ~clk;

  hpd_top uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_busy(dma_busy), .hblank(hblank), .vblank(vblank),
    .mem_req(mem_req), .mem_we(mem_we), .mem_target(mem_target),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dma_start(dma_start), .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val)
  );

  function automatic logic [15:0] mem_fn(input logic [1:0] t, input logic [15:0] a);
    return (a * 16'd3) ^ {t, 14'h0A5C};
  endfunction

  assign mem_rdata = mem_fn(mem_target, mem_addr);

  // reference model state
  bit          m_pend = 0, m_wr = 0;
  logic [15:0] m_first = '0, m_addr = '0;
  int          m_tgt = 0;
  bit          rd_due = 0;
  int          rd_tgt = 0;
  logic [15:0] rd_addr = '0;
  bit          e_req = 0, e_we = 0, e_dma = 0, e_rwe = 0;
  int          e_tgt = 0;
  logic [15:0] e_addr = '0, e_wd = '0, e_rd = '0;
  int          e_idx = 0, e_val = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_wr = 0; m_first = '0; m_addr = '0; m_tgt = 0; rd_due = 0;
      e_req = 0; e_we = 0; e_dma = 0; e_rwe = 0; e_rd = '0;
    end else begin
      e_req = 0; e_dma = 0; e_rwe = 0;
      if (rd_due) begin
        e_rd = mem_fn(rd_tgt[1:0], rd_addr);
        rd_due = 0;
      end
      if (bus_sel) begin
        if (!bus_addr[2]) begin
          if (bus_wr == m_wr) begin
            e_req = 1; e_we = bus_wr; e_tgt = m_tgt;
            e_addr = {m_addr[15:1], 1'b0};
            if (bus_wr) e_wd = bus_wdata;
            else begin rd_due = 1; rd_tgt = m_tgt; rd_addr = e_addr; end
          end
          m_addr = m_addr + 16'd2;
          m_pend = 0;
        end else if (!bus_wr) begin
          e_rd = {12'h000, vblank, hblank, dma_busy, 1'b0};
          m_pend = 0;
        end else if (m_pend) begin
          m_pend = 0;
          m_addr = {bus_wdata[1:0], m_first[13:0]};
          m_wr = m_first[14];
          if (m_first[15:14] == 2'b11 || bus_wdata[5]) m_tgt = 1;
          else if (bus_wdata[4]) m_tgt = 2;
          else m_tgt = 0;
          if (bus_wdata[7]) begin
            e_dma = 1; e_tgt = m_tgt; e_addr = {m_addr[15:1], 1'b0};
          end
        end else if (bus_wdata[15:14] == 2'b10) begin
          if (bus_wdata[13:8] <= 6'd23) begin
            e_rwe = 1; e_idx = bus_wdata[12:8]; e_val = bus_wdata[7:0];
          end
        end else begin
          m_pend = 1; m_first = bus_wdata;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(mem_req == e_req, "mem_req", mem_req, e_req);
    chk(dma_start == e_dma, "dma_start", dma_start, e_dma);
    chk(reg_we == e_rwe, "reg_we", reg_we, e_rwe);
    chk(bus_rdata == e_rd, "bus_rdata", bus_rdata, e_rd);
    if (e_req) begin
      chk(mem_we == e_we, "mem_we", mem_we, e_we);
      if (e_we) chk(mem_wdata == e_wd, "mem_wdata", mem_wdata, e_wd);
    end
    if (e_req || e_dma) begin
      chk(mem_addr == e_addr, "mem_addr", mem_addr, e_addr);
      chk(int'(mem_target) == e_tgt, "mem_target", mem_target, e_tgt);
    end
    if (e_rwe) begin
      chk(int'(reg_idx) == e_idx, "reg_idx", reg_idx, e_idx);
      chk(int'(reg_val) == e_val, "reg_val", reg_val, e_val);
    end
  end

  task automatic acc(input bit wr, input logic [2:1] off, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = off; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic ctl(input logic [15:0] d);
    acc(1, 2'b10, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 5000) begin @(posedge clk); wd++; end
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<5000", wd);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    cur_req = "R0 reset";
    idle(3);
    rst_n = 1;
    idle(2);
    // R2 graphics write, odd address (R5), alternating data offsets (R1), step (R6)
    cur_req = "R2";
    ctl(16'h5235); ctl(16'h0000);
    cur_req = "R1 R5 R6";
    acc(1, 2'b00, 16'hAAAA); acc(1, 2'b01, 16'hBBBB); acc(1, 2'b00, 16'hCCCC);
    idle(1);
    // R10 register writes, including out-of-range ones
    cur_req = "R10";
    ctl(16'h8512); ctl(16'h9733); ctl(16'h9844); ctl(16'hBF01); idle(2);
    // R3 color write through control alias offset 6 (R1)
    cur_req = "R3 R1";
    acc(1, 2'b11, 16'hC042); acc(1, 2'b11, 16'h0000);
    acc(1, 2'b00, 16'h0EEE); acc(1, 2'b00, 16'h0222);
    // R3 color read, back-to-back reads (R7)
    cur_req = "R3 R7";
    ctl(16'h0010); ctl(16'h0020);
    acc(0, 2'b00, 16'h0); acc(0, 2'b01, 16'h0); idle(2);
    // R4 vertical scroll write then read
    cur_req = "R4";
    ctl(16'h4004); ctl(16'h0010); acc(1, 2'b00, 16'h01FF);
    ctl(16'h0002); ctl(16'h0010); acc(0, 2'b00, 16'h0); idle(2);
    // R6 wrap at top of address space, R2 high bits from second word
    cur_req = "R6 R2";
    ctl(16'h7FFE); ctl(16'h0003);
    acc(1, 2'b00, 16'h1111); acc(1, 2'b00, 16'h2222);
    // R7 mismatched direction: no request, address still advances
    cur_req = "R7";
    acc(0, 2'b00, 16'h0); acc(1, 2'b00, 16'h3333); idle(2);
    // R9 status bits
    cur_req = "R9";
    dma_busy = 1; acc(0, 2'b10, 16'h0);
    dma_busy = 0; hblank = 1; acc(0, 2'b11, 16'h0);
    hblank = 0; vblank = 1; acc(0, 2'b10, 16'h0);
    dma_busy = 1; hblank = 1; acc(0, 2'b10, 16'h0);
    dma_busy = 0; hblank = 0; vblank = 0;
    // R11 pending cleared by status read and by data access
    cur_req = "R11";
    ctl(16'h4100); acc(0, 2'b10, 16'h0); ctl(16'h8A05);
    ctl(16'h4100); acc(0, 2'b00, 16'h0); ctl(16'h8A06);
    ctl(16'h4100); ctl(16'h8A07); acc(1, 2'b00, 16'h4444); idle(2);
    // R8 block transfer start
    cur_req = "R8";
    ctl(16'h4101); ctl(16'h0081); idle(1);
    ctl(16'hC020); ctl(16'h0080); idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule